// File: doc/BRIEF.md
# Conditional Slot Sequencer

This block decides, instruction by instruction, whether an instruction that sits inside a predicated group of up to four instructions should execute. It holds an 8-bit predication state. The top three bits of the state are the base of the condition. The lower bits form a shifting mask that gives the final condition bit for each slot and also marks how many slots remain. For the active condition it takes the current four status flags (negative, zero, carry, overflow) and produces an execute-enable.

A decode stage loads a new state when a predicated group begins. It pulses the advance strobe once for each instruction that retires. The state steps to the next slot on each advance and clears itself after the last slot. While the state is zero the block is idle, and the execute decision comes from an external 4-bit condition. Ordinary conditional instructions outside a group use that path.

Top module: `it_seq_top`

## Requirements
- R1: While reset is asserted and after it is released, the state is zero: `in_block_o` is low and `cond_o` equals `ext_cond_i`.
- R2: When `load_i` is high at a clock edge, the state takes `load_state_i`, whatever `adv_i` is. A load has priority over an advance in the same cycle. After the load, `in_block_o` is high exactly when the loaded value is nonzero.
- R3: An advance without a load keeps state bits [7:5]. Bits [4:0] become the old bits [3:0] followed by a 0. While the state is nonzero, `cond_o` is state bits [7:4].
- R4: If an advance leaves the low four state bits all zero, the whole state becomes zero and `in_block_o` falls at that edge.
- R5: While the state is zero, `cond_o` follows `ext_cond_i`, and an advance leaves the state at zero.
- R6: With neither load nor advance, the state holds.
- R7: Condition codes 4'b1110 and 4'b1111 always give `exec_o` = 1.
- R8: With flags packed as `flags_i` = {N,Z,C,V}, codes 0..7 test one flag. 0 means Z set and 1 means Z clear. 2 means C set and 3 means C clear. 4 means N set and 5 means N clear. 6 means V set and 7 means V clear.
- R9: Code 8 is true when C is set and Z is clear. Code 9 is its inverse.
- R10: Code 10 is true when N equals V, and code 11 is its inverse. Code 12 is code 10 with Z clear, and code 13 is the inverse of code 12.
- R11: `exec_o` is combinational from the current state, `ext_cond_i` and `flags_i`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Start a group with `load_state_i` |
| load_state_i | input | 8 | New predication state |
| adv_i | input | 1 | One instruction retired, step to the next slot |
| flags_i | input | 4 | Status flags {N,Z,C,V} |
| ext_cond_i | input | 4 | Condition used while idle |
| exec_o | output | 1 | Current instruction executes |
| in_block_o | output | 1 | State is nonzero |
| cond_o | output | 4 | Active condition code |

## Verification
`exec_o` and `cond_o` respond within the same cycle to changes of the flags and the external condition. The bench therefore drives new inputs on the falling edge and compares these outputs 2 ns later, before the next rising edge. A load or an advance first shows on `in_block_o` and `cond_o` one rising edge after it was driven. The reference model applies its state update only after that edge, so each comparison sees the state the design holds in that same cycle.

// File: rtl/it_seq_pkg.sv
package it_seq_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // base tests selected by cond[3:1]; cond[0] inverts (except base 7)
  typedef enum logic [2:0] {
    B_ZERO  = 3'd0,
    B_CARRY = 3'd1,
    B_NEG   = 3'd2,
    B_OVF   = 3'd3,
    B_HIGH  = 3'd4,
    B_GEQ   = 3'd5,
    B_GTR   = 3'd6,
    B_ALW   = 3'd7
  } base_e;
endpackage

// File: rtl/it_cond_eval.sv
module it_cond_eval
  import it_seq_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       pass_o
);
  base_e base;
  logic  base_true;
  logic  n_eq_v;

  assign base   = base_e'(cond_i[3:1]);
  assign n_eq_v = (flags_i.n == flags_i.v);

  always_comb begin
    unique case (base)
      B_ZERO:  base_true = flags_i.z;
      B_CARRY: base_true = flags_i.c;
      B_NEG:   base_true = flags_i.n;
      B_OVF:   base_true = flags_i.v;
      B_HIGH:  base_true = flags_i.c & ~flags_i.z;
      B_GEQ:   base_true = n_eq_v;
      B_GTR:   base_true = ~flags_i.z & n_eq_v;
      default: base_true = 1'b1;
    endcase
  end

  // both codes of the last base pair are unconditional
  assign pass_o = (base == B_ALW) ? 1'b1 : (base_true ^ cond_i[0]);
endmodule

// File: rtl/it_state_reg.sv
module it_state_reg #(
  parameter int STATE_W = 8,
  parameter int COND_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [STATE_W-1:0] load_val_i,
  input  logic               adv_i,
  output logic [STATE_W-1:0] state_o
);
  localparam int LOW_W  = STATE_W - COND_W;
  localparam int KEEP_W = COND_W - 1;

  logic [STATE_W-1:0] state_q, stepped, state_d;

  // keep condition base, shift mask (and condition lsb) up by one
  assign stepped = {state_q[STATE_W-1 -: KEEP_W], state_q[LOW_W-1:0], 1'b0};

  always_comb begin
    state_d = state_q;
    if (load_i) begin
      state_d = load_val_i;
    end else if (adv_i) begin
      state_d = (stepped[LOW_W-1:0] == '0) ? '0 : stepped;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/it_cond_select.sv
module it_cond_select #(
  parameter int STATE_W = 8,
  parameter int COND_W  = 4
) (
  input  logic [STATE_W-1:0] state_i,
  input  logic [COND_W-1:0]  ext_cond_i,
  output logic [COND_W-1:0]  cond_o,
  output logic               active_o
);
  assign active_o = (state_i != '0);
  assign cond_o   = active_o ? state_i[STATE_W-1 -: COND_W] : ext_cond_i;
endmodule

// File: rtl/it_seq_top.sv
module it_seq_top
  import it_seq_pkg::*;
#(
  parameter int STATE_W = 8,
  parameter int COND_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [STATE_W-1:0] load_state_i,
  input  logic               adv_i,
  input  logic [3:0]         flags_i,
  input  logic [COND_W-1:0]  ext_cond_i,
  output logic               exec_o,
  output logic               in_block_o,
  output logic [COND_W-1:0]  cond_o
);
  logic [STATE_W-1:0] state_q;
  logic [COND_W-1:0]  cond;

  it_state_reg #(.STATE_W(STATE_W), .COND_W(COND_W)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_val_i (load_state_i),
    .adv_i      (adv_i),
    .state_o    (state_q)
  );

  it_cond_select #(.STATE_W(STATE_W), .COND_W(COND_W)) u_sel (
    .state_i    (state_q),
    .ext_cond_i (ext_cond_i),
    .cond_o     (cond),
    .active_o   (in_block_o)
  );

  it_cond_eval u_eval (
    .cond_i  (cond[3:0]),
    .flags_i (flags_t'(flags_i)),
    .pass_o  (exec_o)
  );

  assign cond_o = cond;
endmodule

// File: rtl/it_seq_chk.sv
module it_seq_chk #(
  parameter int STATE_W = 8,
  parameter int COND_W  = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic [STATE_W-1:0] load_state_i,
  input logic               adv_i,
  input logic [COND_W-1:0]  ext_cond_i,
  input logic               exec_o,
  input logic               in_block_o,
  input logic [COND_W-1:0]  cond_o,
  input logic [STATE_W-1:0] state_q
);
  localparam int LOW_W = STATE_W - COND_W;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> state_q == $past(load_state_i));

  assert_keep_base_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i && in_block_o) |=>
      (state_q == '0) || (state_q[STATE_W-1 -: COND_W-1] == $past(cond_o[COND_W-1:1])));

  assert_auto_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i) |=> (state_q == '0) || (state_q[LOW_W-1:0] != '0));

  assert_idle_ext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == '0) |-> (!in_block_o && cond_o == ext_cond_i));

  assert_idle_adv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i && !in_block_o) |=> !in_block_o);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(state_q));

  assert_always_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_o[COND_W-1:1] == '1) |-> exec_o);
endmodule

bind it_seq_top it_seq_chk #(.STATE_W(STATE_W), .COND_W(COND_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .load_i       (load_i),
  .load_state_i (load_state_i),
  .adv_i        (adv_i),
  .ext_cond_i   (ext_cond_i),
  .exec_o       (exec_o),
  .in_block_o   (in_block_o),
  .cond_o       (cond_o),
  .state_q      (state_q)
);

// File: tb/it_seq_top_tb.sv
`timescale 1ns/1ps
module it_seq_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [7:0] ld_val = '0;
  logic       adv = 1'b0;
  logic [3:0] flags = '0;
  logic [3:0] ext = '0;
  logic       exec;
  logic       inb;
  logic [3:0] cond;

  int checks = 0;
  int errors = 0;
  int st = 0;  // reference state

  always #4 clk = ~clk;

  it_seq_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .load_state_i(ld_val),
    .adv_i(adv), .flags_i(flags), .ext_cond_i(ext),
    .exec_o(exec), .in_block_o(inb), .cond_o(cond)
  );

  function automatic bit ref_eval(int c, logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      0: return z;
      1: return !z;
      2: return cy;
      3: return !cy;
      4: return n;
      5: return !n;
      6: return v;
      7: return !v;
      8: return cy && !z;
      9: return !cy || z;
      10: return n == v;
      11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (state %0h)", tag, act, exp, st);
    end
  endtask

  task automatic compare_now();
    int ec = (st != 0) ? (st >> 4) : int'(ext);
    chk((st != 0) ? "R3 cond" : "R5 cond", int'(cond), ec);
    chk("R4 in_block", int'(inb), int'(st != 0));
    if (ec >= 14)     chk("R7 R11 exec", int'(exec), int'(ref_eval(ec, flags)));
    else if (ec < 8)  chk("R8 R11 exec", int'(exec), int'(ref_eval(ec, flags)));
    else if (ec < 10) chk("R9 R11 exec", int'(exec), int'(ref_eval(ec, flags)));
    else              chk("R10 R11 exec", int'(exec), int'(ref_eval(ec, flags)));
  endtask

  task automatic step(bit l, logic [7:0] lv, bit a, logic [3:0] f, logic [3:0] e);
    @(negedge clk);
    load = l; ld_val = lv; adv = a; flags = f; ext = e;
    #2;
    compare_now();
    @(posedge clk);
    if (l) st = lv;               // R2: load wins
    else if (a) begin
      st = (st & 'he0) | ((st * 2) & 'h1f);
      if ((st & 'hf) == 0) st = 0;
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #2;
    chk("R1 in_block in reset", int'(inb), 0);
    chk("R1 cond in reset", int'(cond), int'(ext));
    @(negedge clk);
    rst_n = 1'b1;
    // all conditions against all flag patterns while idle; advances ignored
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        step(1'b0, 8'h00, f[0], 4'(f), 4'(c));
    // groups: load, step through, with idles and load-over-advance
    for (int g = 0; g < 400; g++) begin
      logic [7:0] v = 8'($urandom);
      if (g % 23 == 0) v = 8'h00;
      step(1'b1, v, g[0], 4'($urandom), 4'($urandom));  // R2 with adv on odd g
      for (int k = 0; k < 6; k++) begin
        bit a = ($urandom % 4) != 0;                      // R6 on idle slots
        bit l = (k == 2) && (g % 7 == 0);
        step(l, 8'($urandom), a, 4'($urandom), 4'($urandom));
      end
    end
    // exact sequence: base 3'b000, mask 1.1.1.1 -> four slots then clear
    step(1'b1, 8'h0f, 1'b0, 4'h4, 4'h0);
    for (int k = 0; k < 5; k++) step(1'b0, 8'h00, 1'b1, 4'h4, 4'hb);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule